// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Core

This block models the control path of a pipelined synchronous burst static RAM, with a small internal memory array organised in byte lanes. A new external address is taken when one of two active-low address strobes is seen at a rising edge. One strobe is the processor strobe and the other is the controller strobe. The same edge samples three chip enables and decides whether the part is selected. The two low address bits seed a two-bit burst counter. An active-low advance input steps that counter in linear order, modulo 4, while the upper address bits stay where they were loaded.

Every edge at which the part is selected performs exactly one access, either a write or a read. A write writes all byte lanes when the global write input is low. Otherwise it writes only the lanes whose byte select is low, and only when the byte-write enable is low. Read data is registered and is presented in the cycle after the edge that carried its address. The data-out enable follows the asynchronous output enable, but it stays low on the first read after a deselected period, during writes and while deselected.

The access state machine has four states. ST_IDLE means deselected, and it is the reset state. ST_RD_FIRST is a read that left ST_IDLE, with the output masked. ST_RD is a following read, with the output gated by the output enable. ST_WR means a write was done. The next state is chosen as follows. With no access the machine goes to ST_IDLE. A write goes to ST_WR. A read from ST_IDLE goes to ST_RD_FIRST. A read from any other state goes to ST_RD.

Top module: `sburst_sram_core`

## Requirements
- R1: While reset is asserted and after its release, `rdata_en` is 0 and the core is deselected until a strobe selects it.
- R2: When both strobes are low and `ce1_n` is low, the processor strobe is taken, so the write controls at that edge have no effect and the edge is a read.
- R3: The processor strobe is ignored when `ce1_n` is high. If the controller strobe is also high, the edge continues the current access. If the controller strobe is low, the controller strobe is taken.
- R4: Chip enables are examined only at edges that take a strobe. At other edges they do not change whether the core is selected.
- R5: A taken strobe registers the full address and loads address bits 1:0 into the burst counter. The access at that edge uses the presented address.
- R6: At a selected edge with no strobe and `adv_n` low, the counter increments before the access (3 wraps to 0). Address bits above bit 1 stay unchanged.
- R7: A write with `gw_n` low updates all byte lanes, whatever `bwe_n` and `bw_n` are.
- R8: With `gw_n` high, a write happens only when `bwe_n` is low, and it updates only the lanes `i` (bits `8*i+7:8*i`) whose `bw_n[i]` is low. With both high the edge is a read.
- R9: Read data for the address accessed at an edge appears on `rdata` in the following cycle.
- R10: The first read after a deselected period never drives `rdata_en`.
- R11: Apart from R10, `rdata_en` is high exactly after a read edge while `oe_n` is low. It is 0 after write edges and while `oe_n` is high.
- R12: A strobe taken while any chip enable is inactive (`ce1_n` high, `ce2` low or `ce3_n` high) deselects the core. Nothing is written while it is deselected.
- R13: An edge that takes the processor strobe is always a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, sampled at strobe edges |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 8*NB | Write data |
| rdata | output | 8*NB | Registered read data |
| rdata_en | output | 1 | Data-out drive enable, active high |

## Verification
Array writes take effect at the same edge as their access. Read data and the state that gates `rdata_en` both update at that edge, so each result is due exactly one cycle after the inputs that caused it. `oe_n` acts combinationally on the enable that has been registered. The driver applies inputs at the falling edge, and at the same time it pushes the expected enable and data for that edge into a queue. The monitor pops one item 1 ns after each rising edge and compares it there, so every check falls in the cycle the read latency defines. Ignored writes and ignored strobes are made visible by reading the affected words back through the ports.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_FIRST = 2'd1,
        ST_RD       = 2'd2,
        ST_WR       = 2'd3
    } acc_state_e;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/sbs_strobe.sv
module sbs_strobe #(
    parameter int unsigned NB = 4
) (
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    output logic          load,
    output logic          load_p,
    output logic          sel_ok,
    output logic          wr_req,
    output logic [NB-1:0] lane_we
);

    logic take_p;
    logic take_c;

    // processor strobe only counts with ce1 active; it outranks the controller strobe
    always_comb begin
        take_p = ~adsp_n & ~ce1_n;
        take_c = ~adsc_n & ~take_p;
        load   = take_p | take_c;
        load_p = take_p;
        sel_ok = ~ce1_n & ce2 & ~ce3_n;
        wr_req = ~gw_n | ~bwe_n;
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_we[i] = ~gw_n | (~bwe_n & ~bw_n[i]);
    end

endmodule

// File: rtl/sbs_burst.sv
module sbs_burst #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          active,
    input  logic          adv_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] eff_addr
);

    localparam int unsigned HW = AW - 2;

    logic [HW-1:0] hi_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nx;
    logic          step;

    always_comb begin
        step   = active & ~load & ~adv_n;
        cnt_nx = step ? cnt_q + 2'd1 : cnt_q;
        eff_addr = load ? addr : {hi_q, cnt_nx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            hi_q  <= addr[AW-1:2];
            cnt_q <= addr[1:0];
        end else begin
            cnt_q <= cnt_nx;
        end
    end

    a_r5_seed_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(addr[1:0]));

    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hi_q));

    a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && active && !adv_n) |=> cnt_q == $past(cnt_q) + 2'd1);

endmodule

// File: rtl/sbs_fsm.sv
module sbs_fsm
    import sbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_p,
    input  logic sel_ok,
    input  logic wr_req,
    input  logic oe_n,
    output logic active,
    output logic wr_acc,
    output logic rd_acc,
    output logic rdata_en
);

    acc_state_e state_q;
    acc_state_e state_nx;
    logic       acc;

    always_comb begin
        acc    = load ? sel_ok : (state_q != ST_IDLE);
        wr_acc = acc & wr_req & ~(load & load_p);
        rd_acc = acc & ~wr_acc;
        if (!acc)
            state_nx = ST_IDLE;
        else if (wr_acc)
            state_nx = ST_WR;
        else if (state_q == ST_IDLE)
            state_nx = ST_RD_FIRST;
        else
            state_nx = ST_RD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    always_comb begin
        active   = 1'b1;
        rdata_en = 1'b0;
        unique case (state_q)
            ST_IDLE:     active = 1'b0;
            ST_RD_FIRST: rdata_en = 1'b0;
            ST_RD:       rdata_en = ~oe_n;
            ST_WR:       rdata_en = 1'b0;
        endcase
    end

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!rdata_en);
        end
    end

    a_r10_first_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !active) |=> !rdata_en);

    a_r12_desel_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sel_ok) |=> !active);

    a_r4_keep_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load) |=> active);

    a_r11_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !rdata_en);

endmodule

// File: rtl/sbs_array.sv
module sbs_array
    import sbs_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [AW-1:0]        addr,
    input  logic [NB-1:0]        lane_we,
    input  logic [NB*LANE_W-1:0] wdata,
    output logic [NB*LANE_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && lane_we[i])
                mem[addr] <= wdata[i*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_q <= '0;
            else if (rd_en)
                rd_q <= mem[addr];
        end

        assign rdata[i*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/sburst_sram_core.sv
module sburst_sram_core
    import sbs_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4,
    localparam int unsigned DW = NB * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          oe_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_en
);

    logic          load;
    logic          load_p;
    logic          sel_ok;
    logic          wr_req;
    logic [NB-1:0] lane_we;
    logic          active;
    logic          wr_acc;
    logic          rd_acc;
    logic [AW-1:0] eff_addr;

    sbs_strobe #(.NB(NB)) u_strobe (
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .load    (load),
        .load_p  (load_p),
        .sel_ok  (sel_ok),
        .wr_req  (wr_req),
        .lane_we (lane_we)
    );

    sbs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_p   (load_p),
        .sel_ok   (sel_ok),
        .wr_req   (wr_req),
        .oe_n     (oe_n),
        .active   (active),
        .wr_acc   (wr_acc),
        .rd_acc   (rd_acc),
        .rdata_en (rdata_en)
    );

    sbs_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .active   (active),
        .adv_n    (adv_n),
        .addr     (addr),
        .eff_addr (eff_addr)
    );

    sbs_array #(.AW(AW), .NB(NB)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_acc),
        .rd_en   (rd_acc),
        .addr    (eff_addr),
        .lane_we (lane_we),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    a_r2_proc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !adsc_n && !ce1_n) |-> !wr_acc);

    a_r3_proc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && adsc_n && ce1_n && !active) |=> !active);

    a_r13_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> !wr_acc);

endmodule

// File: tb/sburst_sram_core_tb.sv
`timescale 1ns/1ps
module sburst_sram_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        adsp_n = 1'b1, adsc_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic        adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdata_en;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sburst_sram_core u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    // reference model and scoreboard
    logic [31:0] ref_mem [64];
    logic        m_active = 1'b0;
    logic [3:0]  m_hi = '0;
    logic [1:0]  m_cnt = '0;
    logic        q_en [$];
    logic [31:0] q_data [$];
    string       q_tag [$];

    task automatic cyc(input logic p_n, c_n, v_n, e1_n, e2, e3_n, g_n, b_n,
                       input logic [3:0] bws_n, input logic o_n,
                       input logic [5:0] a, input logic [31:0] d, input string tag);
        logic p_take, c_take, ld, sel, wr, rd, was;
        logic [5:0] ea;
        @(negedge clk);
        adsp_n = p_n; adsc_n = c_n; adv_n = v_n; ce1_n = e1_n; ce2 = e2; ce3_n = e3_n;
        gw_n = g_n; bwe_n = b_n; bw_n = bws_n; oe_n = o_n; addr = a; wdata = d;
        p_take = !p_n && !e1_n;
        c_take = !c_n && !p_take;
        ld     = p_take || c_take;
        was    = m_active;
        if (ld) begin
            sel = !e1_n && e2 && !e3_n;
            ea = a; m_hi = a[5:2]; m_cnt = a[1:0];
        end else begin
            sel = m_active;
            if (m_active && !v_n) m_cnt = m_cnt + 2'd1;
            ea = {m_hi, m_cnt};
        end
        wr = sel && (!g_n || !b_n) && !p_take;
        rd = sel && !wr;
        if (wr)
            for (int i = 0; i < 4; i++)
                if (!g_n || !bws_n[i]) ref_mem[ea][8*i +: 8] = d[8*i +: 8];
        q_en.push_back(rd && was && !o_n);
        q_data.push_back(ref_mem[ea]);
        q_tag.push_back(tag);
        m_active = sel;
    endtask

    task automatic quiet(input string tag);
        cyc(1,1,1, 1,0,1, 1,1,4'hF,1, 6'd0, 32'd0, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_en.size() > 0) begin
                logic e; logic [31:0] dv; string t;
                e = q_en.pop_front(); dv = q_data.pop_front(); t = q_tag.pop_front();
                checks++;
                if (rdata_en !== e || (e && rdata !== dv)) begin
                    fails++;
                    $display("FAIL %s: en=%0b data=%08h expected en=%0b data=%08h",
                             t, rdata_en, rdata, e, dv);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (rdata_en !== 1'b0) begin
            fails++;
            $display("FAIL R1: en=%0b expected en=0", rdata_en);
        end
        rst_n = 1'b1;
        quiet("R1");
        // R7 global write via controller strobe, then R6 burst writes 9..11
        cyc(1,0,1, 0,1,0, 0,1,4'hF,0, 6'd8,  32'h11223344, "R7");
        cyc(1,1,0, 0,1,0, 0,1,4'hF,0, 6'd0,  32'h55667788, "R6");
        cyc(1,1,0, 0,1,0, 0,1,4'hF,0, 6'd0,  32'h99aabbcc, "R6");
        cyc(1,1,0, 0,1,0, 0,1,4'hF,0, 6'd0,  32'hddeeff00, "R6");
        // R12 deselecting load with a write request
        cyc(1,0,1, 0,0,0, 0,1,4'hF,0, 6'd8,  32'hdeadbeef, "R12");
        // R10 first read after deselect masked, then burst with wrap (R6), latency (R9)
        cyc(0,1,1, 0,1,0, 1,1,4'hF,0, 6'd10, 32'd0, "R10");
        cyc(1,1,0, 1,0,1, 1,1,4'hF,0, 6'd0,  32'd0, "R6");
        cyc(1,1,0, 1,0,1, 1,1,4'hF,0, 6'd0,  32'd0, "R6");
        cyc(1,1,0, 1,0,1, 1,1,4'hF,0, 6'd0,  32'd0, "R9");
        cyc(1,1,1, 0,1,0, 1,1,4'hF,1, 6'd0,  32'd0, "R11");
        cyc(1,1,1, 1,0,1, 1,1,4'hF,0, 6'd0,  32'd0, "R4");
        // R8 byte write lanes 0 and 2, then read back with bwe high
        cyc(1,0,1, 0,1,0, 1,0,4'b1010,0, 6'd9, 32'haabbccdd, "R8");
        cyc(1,0,1, 0,1,0, 1,1,4'h0,0, 6'd9,  32'hffffffff, "R8");
        // R2 both strobes, write controls ignored; R13 readback
        cyc(0,0,1, 0,1,0, 0,0,4'h0,0, 6'd8,  32'h0badf00d, "R2");
        cyc(1,0,1, 0,1,0, 1,1,4'hF,0, 6'd8,  32'd0, "R13");
        // R3 processor strobe with ce1 high: continuation, then controller takes it
        cyc(0,1,1, 1,1,0, 1,1,4'hF,0, 6'd12, 32'd0, "R3");
        cyc(0,0,1, 1,1,0, 1,1,4'hF,0, 6'd12, 32'd0, "R3");
        quiet("R12");
        // R5 seeding from low bits, wrap from 3
        cyc(1,0,1, 0,1,0, 1,1,4'hF,0, 6'd11, 32'd0, "R10");
        cyc(1,1,0, 0,1,0, 1,1,4'hF,0, 6'd0,  32'd0, "R5");
        cyc(1,0,1, 0,1,0, 1,1,4'hF,0, 6'd10, 32'd0, "R5");
        quiet("R11");
        quiet("R11");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule